// File: doc/BRIEF.md
# Gradient-Direction Ridge Thinning Stage

This stage turns a stream of gradient magnitudes into ridges one pixel wide. Each pixel arrives with three values: its 8-bit magnitude and the signed horizontal and vertical gradient components. The block holds a 3x3 window of magnitudes around every pixel and reduces the gradient direction to one of four axes. It then picks the two window neighbours that lie along that axis, one on each side of the centre. A centre that stands out from that pair along the direction keeps its magnitude. Every other pixel leaves the block as zero.

The input is a raster stream with fixed line timing. Every line period is exactly `H_TOTAL` clocks. Active pixels are marked by `in_valid`, and each active line's pixels arrive in back-to-back cycles. `in_sol` marks the first pixel of a line and `in_sof` marks the first pixel of a frame. The window is built from two free-running line delays, so the pipeline moves on every clock, including blanking. Every output therefore comes a fixed number of clocks after its input. The last row of a frame is only released while the next line period runs, so at least one blanking line must follow each frame.

Top module: `nms_thin`

## Requirements
- R1: A pixel sampled at a clock edge appears at the outputs exactly `H_TOTAL`+2 clock edges later, and `out_valid` repeats `in_valid` with that same delay.
- R2: A pixel in the first or last active row of the frame, or in the first or last active column of its line, leaves as magnitude 0. `ACT_H` and `ACT_W` give the active row and column counts.
- R3: Let ax=|gx| and ay=|gy|. Rows grow downward and columns grow rightward, and a positive gy points toward the next row. The neighbour pair is chosen as follows:
  - Left/right, when 256*ay <= 106*ax. This includes gx=gy=0.
  - Otherwise above/below, when 256*ay >= 618*ax.
  - Otherwise, if gx and gy have the same sign, the pair is upper-left/lower-right.
  - Otherwise it is upper-right/lower-left.
- R4: With centre C and chosen neighbours P and Q, a non-border pixel keeps C when (C > P and C >= Q) or (C > Q and C >= P).
- R5: A non-border valid pixel that fails the R4 test leaves as magnitude 0.
- R6: When `out_valid` is low, `out_mag` is 0.
- R7: After reset, and until the first sampled pixel has come through, `out_valid`, `out_sof` and `out_sol` are low and `out_mag` is 0.
- R8: `out_sof` and `out_sol` repeat the input line and frame markers with the R1 delay. Row counting restarts at each frame start and column counting restarts at each line start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Active pixel present this cycle |
| in_sof | input | 1 | First pixel of a frame (also a line start) |
| in_sol | input | 1 | First pixel of a line |
| in_mag | input | MW | Gradient magnitude, unsigned |
| in_gx | input | GW | Horizontal gradient, signed |
| in_gy | input | GW | Vertical gradient, signed, positive downward |
| out_valid | output | 1 | Delayed active-pixel flag |
| out_sof | output | 1 | Delayed frame start |
| out_sol | output | 1 | Delayed line start |
| out_mag | output | MW | Thinned magnitude, 0 where suppressed |

## Verification
A read/write pointer that slips in a line delay moves the above or below neighbours by one column. Such a fault shows up on the first interior row whose values differ across columns, within one line period. A mix-up in the direction decode or the neighbour mux affects only pixels whose gradient falls in the wrong sector, and the output is wrong in the very cycle that pixel leaves. The bench therefore drives strong random gradients in one frame and small, tie-heavy values in another, and compares every output cycle against a per-cycle reference. A sideband delay that is off by one cycle shows at once on the first `out_sol` of the frame.

// File: rtl/nms_pkg.sv
`timescale 1ns/1ps
// Shared types for the ridge-thinning stage.
package nms_pkg;
    // Axis along which the centre is compared with its two neighbours.
    // DIR_FALL: gx and gy share a sign (upper-left / lower-right pair).
    // DIR_RISE: opposite signs (upper-right / lower-left pair).
    typedef enum logic [1:0] {
        DIR_ROW  = 2'd0,
        DIR_FALL = 2'd1,
        DIR_COL  = 2'd2,
        DIR_RISE = 2'd3
    } dir_e;
endpackage

// File: rtl/nms_line_delay.sv
`timescale 1ns/1ps
// Free-running delay of DEPTH clocks, built as a circular buffer.
// Assumes: the write happens every clock. The read returns the word
// written DEPTH edges earlier. 'primed' rises once every entry has been
// written since reset; until then the read data is meaningless.
module nms_line_delay #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          primed
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] store [DEPTH];
    logic [AW-1:0] ptr;

    // Walk the shared read/write pointer around the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) ptr <= '0;
        else        ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
    end

    // Mark the buffer as filled after one full lap.
    always_ff @(posedge clk) begin
        if (!rst_n)            primed <= 1'b0;
        else if (ptr == LAST)  primed <= 1'b1;
    end

    // Overwrite the oldest entry with the new word.
    always_ff @(posedge clk) begin
        store[ptr] <= wr_data;
    end

    assign rd_data = store[ptr];
endmodule

// File: rtl/nms_raster_pos.sv
`timescale 1ns/1ps
// Tracks the row and column of the pixel on the input and flags pixels
// on the frame border (first/last active row or column).
// Assumes: in_sof only comes with in_sol. Counters saturate, so stray
// lines before the first frame start count as border.
module nms_raster_pos #(
    parameter int ACT_W = 48,
    parameter int ACT_H = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sof,
    input  logic in_sol,
    output logic on_border
);
    localparam int CW = $clog2(ACT_W + 1);
    localparam int RW = $clog2(ACT_H + 1);
    localparam logic [CW-1:0] COL_MAX = CW'(ACT_W);
    localparam logic [RW-1:0] ROW_MAX = RW'(ACT_H);
    localparam logic [CW-1:0] COL_END = CW'(ACT_W - 1);
    localparam logic [RW-1:0] ROW_END = RW'(ACT_H - 1);

    logic [CW-1:0] col_q, col_cur;
    logic [RW-1:0] row_q, row_cur;

    // Position of the pixel presented in this cycle.
    always_comb begin
        col_cur = in_sol ? '0 : col_q;
        if (in_sof)      row_cur = '0;
        else if (in_sol) row_cur = (row_q == ROW_MAX) ? row_q : row_q + 1'b1;
        else             row_cur = row_q;
    end

    // Advance the counters on each active pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= COL_MAX;
            row_q <= ROW_MAX;
        end else if (in_valid) begin
            col_q <= (col_cur == COL_MAX) ? col_cur : col_cur + 1'b1;
            row_q <= row_cur;
        end
    end

    assign on_border = (row_cur == '0) || (row_cur >= ROW_END) ||
                       (col_cur == '0) || (col_cur >= COL_END);
endmodule

// File: rtl/nms_dir_quant.sv
`timescale 1ns/1ps
// Reduces a gradient vector to one of four comparison axes. The 22.5
// and 67.5 degree tangents are fixed-point constants scaled by 2^FRAC.
// Assumes: gy is positive toward the next row.
module nms_dir_quant
    import nms_pkg::*;
#(
    parameter int GW     = 9,
    parameter int FRAC   = 8,
    parameter int TAN_LO = 106,
    parameter int TAN_HI = 618
) (
    input  logic signed [GW-1:0] gx,
    input  logic signed [GW-1:0] gy,
    output dir_e                 dir
);
    localparam int PW = GW + FRAC + 2;
    localparam logic [PW-1:0] K_LO = PW'(TAN_LO);
    localparam logic [PW-1:0] K_HI = PW'(TAN_HI);

    logic [GW-1:0] ax, ay;
    logic [PW-1:0] ay_scaled, ax_lo, ax_hi;

    // Absolute values; the most negative code maps to its unsigned magnitude.
    always_comb begin
        ax = gx[GW-1] ? GW'(-gx) : GW'(gx);
        ay = gy[GW-1] ? GW'(-gy) : GW'(gy);
    end

    // Scale both sides so the tangents compare as integers.
    always_comb begin
        ay_scaled = PW'(ay) << FRAC;
        ax_lo     = PW'(ax) * K_LO;
        ax_hi     = PW'(ax) * K_HI;
    end

    // Pick the sector; the horizontal test takes priority.
    always_comb begin
        if (ay_scaled <= ax_lo)          dir = DIR_ROW;
        else if (ay_scaled >= ax_hi)     dir = DIR_COL;
        else if (gx[GW-1] == gy[GW-1])   dir = DIR_FALL;
        else                             dir = DIR_RISE;
    end
endmodule

// File: rtl/nms_peak_test.sv
`timescale 1ns/1ps
// Decides whether the centre survives against its two directional
// neighbours: it must be no smaller than both and strictly above one.
module nms_peak_test #(
    parameter int MW = 8
) (
    input  logic [MW-1:0] centre,
    input  logic [MW-1:0] side_p,
    input  logic [MW-1:0] side_q,
    output logic          keep
);
    // Mixed strict/non-strict comparison.
    always_comb begin
        keep = ((centre > side_p) && (centre >= side_q)) ||
               ((centre > side_q) && (centre >= side_p));
    end
endmodule

// File: rtl/nms_thin.sv
`timescale 1ns/1ps
// Ridge-thinning stage. A 3x3 magnitude window is built from two line
// delays and three column taps per row. The gradient and the sideband
// flags ride one line delay plus two registers, so they stay aligned
// with the window centre. The result is registered once.
// Assumes: every line period is H_TOTAL clocks, the active pixels of a
// line are contiguous, and a blanking line follows each frame.
// Latency: H_TOTAL+2 edges from the sampling edge to the output.
module nms_thin
    import nms_pkg::*;
#(
    parameter int MW      = 8,
    parameter int GW      = 9,
    parameter int H_TOTAL = 64,
    parameter int ACT_W   = 48,
    parameter int ACT_H   = 32,
    parameter int FRAC    = 8,
    parameter int TAN_LO  = 106,
    parameter int TAN_HI  = 618
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic                 in_sol,
    input  logic [MW-1:0]        in_mag,
    input  logic signed [GW-1:0] in_gx,
    input  logic signed [GW-1:0] in_gy,
    output logic                 out_valid,
    output logic                 out_sof,
    output logic                 out_sol,
    output logic [MW-1:0]        out_mag
);
    localparam int FLAG_W = 4;                  // valid, sof, sol, border
    localparam int CTRL_W = FLAG_W + 2 * GW;
    localparam int WORD_W = CTRL_W + MW;
    localparam int ROWS   = 3;
    localparam int TAPS   = 3;

    logic              px_border;
    logic [WORD_W-1:0] lb1_wr, lb1_rd;
    logic              lb1_primed;
    logic [MW-1:0]     lb2_rd;
    logic              lb2_primed;
    logic [CTRL_W-1:0] ctl_src, ctl_d1, ctl_d2;
    logic [MW-1:0]     row_src [ROWS];
    logic [MW-1:0]     win     [ROWS][TAPS];

    logic                 c_vld, c_sof, c_sol, c_border;
    logic signed [GW-1:0] c_gx, c_gy;
    dir_e                 c_dir;
    logic [MW-1:0]        ctr_mag, nb_p, nb_q;
    logic                 c_keep;

    nms_raster_pos #(.ACT_W(ACT_W), .ACT_H(ACT_H)) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_sol    (in_sol),
        .on_border (px_border)
    );

    // Pack the per-pixel word for the first line delay.
    always_comb begin
        lb1_wr = {in_valid, in_valid & in_sof, in_valid & in_sol, px_border,
                  in_gx, in_gy, in_mag};
    end

    nms_line_delay #(.DEPTH(H_TOTAL), .DW(WORD_W)) u_lb1 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (lb1_wr),
        .rd_data (lb1_rd),
        .primed  (lb1_primed)
    );

    nms_line_delay #(.DEPTH(H_TOTAL), .DW(MW)) u_lb2 (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_data (lb1_rd[MW-1:0]),
        .rd_data (lb2_rd),
        .primed  (lb2_primed)
    );

    // Row sources of the window: top = two lines back, bottom = live input.
    always_comb begin
        row_src[0] = lb2_primed ? lb2_rd : '0;
        row_src[1] = lb1_primed ? lb1_rd[MW-1:0] : '0;
        row_src[2] = in_mag;
        ctl_src    = {lb1_rd[WORD_W-1 -: 3] & {3{lb1_primed}},
                      lb1_rd[WORD_W-4 : MW]};
    end

    // Three column taps per row; tap 0 is the rightmost (newest) column.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int t = 0; t < TAPS; t++) win[r][t] <= '0;
            end else begin
                win[r][0] <= row_src[r];
                for (int t = 1; t < TAPS; t++) win[r][t] <= win[r][t-1];
            end
        end
    end

    // Delay flags and gradient two cycles to meet the window centre.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_d1 <= '0;
            ctl_d2 <= '0;
        end else begin
            ctl_d1 <= ctl_src;
            ctl_d2 <= ctl_d1;
        end
    end

    // Unpack the centre's control word.
    always_comb begin
        c_vld    = ctl_d2[CTRL_W-1];
        c_sof    = ctl_d2[CTRL_W-2];
        c_sol    = ctl_d2[CTRL_W-3];
        c_border = ctl_d2[CTRL_W-4];
        c_gx     = ctl_d2[2*GW-1 : GW];
        c_gy     = ctl_d2[GW-1 : 0];
        ctr_mag  = win[1][1];
    end

    nms_dir_quant #(.GW(GW), .FRAC(FRAC), .TAN_LO(TAN_LO), .TAN_HI(TAN_HI)) u_dir (
        .gx  (c_gx),
        .gy  (c_gy),
        .dir (c_dir)
    );

    // Select the neighbour pair along the quantised direction.
    always_comb begin
        unique case (c_dir)
            DIR_ROW:  begin nb_p = win[1][0]; nb_q = win[1][2]; end
            DIR_COL:  begin nb_p = win[2][1]; nb_q = win[0][1]; end
            DIR_FALL: begin nb_p = win[2][0]; nb_q = win[0][2]; end
            default:  begin nb_p = win[0][0]; nb_q = win[2][2]; end
        endcase
    end

    nms_peak_test #(.MW(MW)) u_peak (
        .centre (ctr_mag),
        .side_p (nb_p),
        .side_q (nb_q),
        .keep   (c_keep)
    );

    // Register the thinned pixel and its sideband.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_sol   <= 1'b0;
            out_mag   <= '0;
        end else begin
            out_valid <= c_vld;
            out_sof   <= c_sof;
            out_sol   <= c_sol;
            out_mag   <= (c_vld && !c_border && c_keep) ? ctr_mag : '0;
        end
    end
endmodule

// File: rtl/nms_thin_chk.sv
`timescale 1ns/1ps
// Property checker for nms_thin, attached by bind.
module nms_thin_chk #(
    parameter int MW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          out_valid,
    input logic          out_sof,
    input logic          out_sol,
    input logic [MW-1:0] out_mag,
    input logic [MW-1:0] ctr_mag,
    input logic [MW-1:0] nb_p,
    input logic [MW-1:0] nb_q
);
    // R6: nothing leaves on an idle cycle.
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> out_mag == '0);

    // R8: a frame start is also a valid line start.
    a_r8_sof_in_line: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> (out_sol && out_valid));

    // R8: line markers only on valid pixels.
    a_r8_sol_valid: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |-> out_valid);

    // R2: the first column of every line is border.
    a_r2_first_col_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |-> out_mag == '0);

    // R4: a surviving value is the previous centre and dominates its pair.
    a_r4_kept_is_peak: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mag != '0) |-> ($past(ctr_mag) == out_mag &&
                             $past(ctr_mag >= nb_p) && $past(ctr_mag >= nb_q) &&
                             $past(nb_p != nb_q || ctr_mag != nb_p)));
endmodule

bind nms_thin nms_thin_chk #(.MW(MW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_valid (out_valid),
    .out_sof   (out_sof),
    .out_sol   (out_sol),
    .out_mag   (out_mag),
    .ctr_mag   (ctr_mag),
    .nb_p      (nb_p),
    .nb_q      (nb_q)
);

// File: tb/nms_thin_tb.sv
`timescale 1ns/1ps
module nms_thin_tb;
    localparam int HT     = 12;
    localparam int AW     = 8;
    localparam int AH     = 6;
    localparam int VBL    = 2;
    localparam int FRAMES = 2;
    localparam int LAT    = HT + 3;   // presentation cycle to output cycle
    localparam int NIN    = FRAMES * (AH + VBL) * HT;
    localparam int NRUN   = NIN + LAT + 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
    logic [7:0]        in_mag = '0;
    logic signed [8:0] in_gx = '0, in_gy = '0;
    logic              out_valid, out_sof, out_sol;
    logic [7:0]        out_mag;

    int  s_mag [NIN];
    int  s_gx  [NIN];
    int  s_gy  [NIN];
    int  s_row [NIN];
    int  s_col [NIN];
    bit  s_vld [NIN];
    bit  s_sof [NIN];
    bit  s_sol [NIN];
    int  n_checks = 0, n_fail = 0;
    int  sec_hits [4];
    bit  done = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    nms_thin #(.MW(8), .GW(9), .H_TOTAL(HT), .ACT_W(AW), .ACT_H(AH)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_sol(in_sol), .in_mag(in_mag), .in_gx(in_gx), .in_gy(in_gy),
        .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol),
        .out_mag(out_mag));

    function automatic int rnd(int range);
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[30:16]) % range;
    endfunction

    // Build the whole input schedule, one entry per clock.
    task automatic build_schedule();
        for (int n = 0; n < NIN; n++) begin
            int f = n / ((AH + VBL) * HT);
            int l = (n / HT) % (AH + VBL);
            int c = n % HT;
            s_row[n] = l; s_col[n] = c;
            s_vld[n] = (l < AH) && (c < AW);
            s_sol[n] = s_vld[n] && (c == 0);
            s_sof[n] = s_sol[n] && (l == 0);
            s_mag[n] = 0; s_gx[n] = 0; s_gy[n] = 0;
            if (s_vld[n]) begin
                if (f == 0) begin
                    s_mag[n] = rnd(256);
                    s_gx[n]  = rnd(512) - 256;
                    s_gy[n]  = rnd(512) - 256;
                end else begin
                    s_mag[n] = 5 + rnd(3);
                    s_gx[n]  = rnd(7) - 3;
                    s_gy[n]  = rnd(7) - 3;
                end
            end
        end
    endtask

    // Reference result for the output cycle n.
    task automatic expect_at(input int n, output bit ev, output bit es,
                             output bit el, output int em, output string tag);
        int src = n - LAT;
        ev = 0; es = 0; el = 0; em = 0; tag = "R6";
        if (src < 0) begin tag = "R7"; return; end
        if (src >= NIN || !s_vld[src]) return;
        ev = 1; es = s_sof[src]; el = s_sol[src];
        if (s_row[src] == 0 || s_row[src] == AH-1 || s_col[src] == 0 || s_col[src] == AW-1) begin
            tag = "R2"; return;
        end
        begin
            int ax = (s_gx[src] < 0) ? -s_gx[src] : s_gx[src];
            int ay = (s_gy[src] < 0) ? -s_gy[src] : s_gy[src];
            int pi, qi, sec, c, p, q;
            if (256 * ay <= 106 * ax) begin sec = 0; pi = src + 1; qi = src - 1; end
            else if (256 * ay >= 618 * ax) begin sec = 2; pi = src + HT; qi = src - HT; end
            else if ((s_gx[src] < 0) == (s_gy[src] < 0)) begin
                sec = 1; pi = src + HT + 1; qi = src - HT - 1;
            end else begin
                sec = 3; pi = src - HT + 1; qi = src + HT - 1;
            end
            sec_hits[sec]++;
            c = s_mag[src]; p = s_mag[pi]; q = s_mag[qi];
            if ((c > p && c >= q) || (c > q && c >= p)) begin em = c; tag = "R4"; end
            else begin em = 0; tag = "R5 R3"; end
        end
    endtask

    task automatic check(input string tag, input bit ok, input int act, input int exp_v, input int n);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, n, act, exp_v);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        build_schedule();
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R7: outputs idle while reset is held.
        check("R7", out_valid == 0 && out_sof == 0 && out_sol == 0 && out_mag == 0,
              {out_valid, out_sof, out_sol, out_mag}, 0, -1);
        rst_n = 1'b1;
        for (int n = 0; n < NRUN; n++) begin
            bit ev, es, el; int em; string tag;
            @(posedge clk); #1;
            if (n < NIN) begin
                in_valid = s_vld[n]; in_sof = s_sof[n]; in_sol = s_sol[n];
                in_mag = 8'(s_mag[n]); in_gx = 9'(s_gx[n]); in_gy = 9'(s_gy[n]);
            end else begin
                in_valid = 0; in_sof = 0; in_sol = 0; in_mag = '0; in_gx = '0; in_gy = '0;
            end
            @(negedge clk);
            expect_at(n, ev, es, el, em, tag);
            // R1: valid delay; R8: line/frame markers follow it.
            if (out_valid != ev)
                check("R1", 0, out_valid, ev, n);
            else
                check("R8", out_sof == es && out_sol == el, {out_sof, out_sol}, {es, el}, n);
            check(tag, int'(out_mag) == em, out_mag, em, n);
        end
        // R3: stimulus reached every direction sector.
        for (int s = 0; s < 4; s++) check("R3", sec_hits[s] > 0, sec_hits[s], 1, s);
        done = 1'b1;
        report();
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual running expected done");
            report();
        end
    end
endmodule